// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address through a small table of base-and-bound pairs. Software fills the table through a write port. The upper two bits of a virtual address pick one of four table entries. The lower 30 bits form an offset. If the offset is greater than the entry's bound, the request faults. If not, the physical address is the entry's base plus the offset, and only the low 30 bits are kept.

Each translation takes one registered cycle. For every request, the block raises either a one-cycle valid pulse carrying the physical address or a one-cycle fault pulse, and never both. A table write issued in the same cycle as a request takes effect only for later requests. After reset, every entry has base 0 and bound 0, so only offset 0 translates and every other offset faults.

Top module: `segxlate_top`

## Requirements
- R1: After reset, both `xl_ok` and `xl_fault` are low, and they stay low in every cycle that follows an idle cycle.
- R2: A request made in cycle N produces its result on the outputs in cycle N+1. Exactly one of `xl_ok` or `xl_fault` is high in that cycle.
- R3: Bits [31:30] of the virtual address select the table entry, and bits [29:0] are the offset.
- R4: If the offset is less than or equal to the selected bound, `xl_ok` rises and `pa` equals (base + offset) modulo 2^30.
- R5: If the offset is greater than the selected bound, `xl_fault` rises, `xl_ok` stays low and `pa` reads zero.
- R6: A write to entry `tw_idx` sets its base and bound from the next cycle onward. A request in the same cycle as the write uses the old contents.
- R7: After reset, every entry has base 0 and bound 0. Offset 0 then translates to address 0, and any nonzero offset faults.
- R8: A write to one entry does not change how the other entries translate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 2 | Entry written |
| tw_base | input | 30 | Physical base written |
| tw_bound | input | 30 | Largest legal offset written |
| xl_req | input | 1 | Translate request |
| va | input | 32 | Virtual address |
| pa | output | 30 | Translated physical address |
| xl_ok | output | 1 | Translation valid pulse |
| xl_fault | output | 1 | Bound violation pulse |

## Verification
The checker tests, on every cycle, the timing and exclusivity of the two result pulses, that `pa` is zero when no valid result is present, and that each result follows a request made in the previous cycle. Whether the address arithmetic is right, how the bound is compared, the ordering of a write against a request in the same cycle, the reset table contents and the isolation between entries depend on which values were loaded. Only the bench's directed scenarios can show these.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 30;
  localparam int SEG_N = 4;
  localparam int IDX_W = $clog2(SEG_N);
  localparam int OFF_W = VA_W - IDX_W;

  typedef struct packed {
    logic [PA_W-1:0]  base;
    logic [OFF_W-1:0] bound;
  } seg_ent_t;
endpackage

// File: rtl/segxlate_table.sv
module segxlate_table
  import segxlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  seg_ent_t         wdat,
  input  logic [IDX_W-1:0] ridx,
  output seg_ent_t         rdat
);
  seg_ent_t ent [SEG_N];

  for (genvar g = 0; g < SEG_N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= '0;
      else if (we && widx == IDX_W'(g))
        ent[g] <= wdat;
    end
  end

  assign rdat = ent[ridx];
endmodule

// File: rtl/segxlate_calc.sv
module segxlate_calc
  import segxlate_pkg::*;
(
  input  seg_ent_t         ent,
  input  logic [OFF_W-1:0] off,
  output logic             in_range,
  output logic [PA_W-1:0]  sum
);
  always_comb begin
    in_range = (off <= ent.bound);
    sum      = PA_W'(ent.base + PA_W'(off));
  end
endmodule

// File: rtl/segxlate_top.sv
module segxlate_top
  import segxlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tw_en,
  input  logic [IDX_W-1:0]  tw_idx,
  input  logic [PA_W-1:0]   tw_base,
  input  logic [OFF_W-1:0]  tw_bound,
  input  logic              xl_req,
  input  logic [VA_W-1:0]   va,
  output logic [PA_W-1:0]   pa,
  output logic              xl_ok,
  output logic              xl_fault
);
  seg_ent_t         sel_ent;
  seg_ent_t         wr_ent;
  logic             hit;
  logic [PA_W-1:0]  phys;

  assign wr_ent.base  = tw_base;
  assign wr_ent.bound = tw_bound;

  segxlate_table u_tab (
    .clk  (clk),
    .rst  (rst),
    .we   (tw_en),
    .widx (tw_idx),
    .wdat (wr_ent),
    .ridx (va[VA_W-1 -: IDX_W]),
    .rdat (sel_ent)
  );

  segxlate_calc u_calc (
    .ent      (sel_ent),
    .off      (va[OFF_W-1:0]),
    .in_range (hit),
    .sum      (phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pa       <= '0;
      xl_ok    <= 1'b0;
      xl_fault <= 1'b0;
    end else begin
      xl_ok    <= xl_req && hit;
      xl_fault <= xl_req && !hit;
      pa       <= (xl_req && hit) ? phys : '0;
    end
  end
endmodule

// File: rtl/segxlate_chk.sv
module segxlate_chk
  import segxlate_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            xl_req,
  input logic [PA_W-1:0] pa,
  input logic            xl_ok,
  input logic            xl_fault
);
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(xl_ok && xl_fault)); // R2
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    xl_req |=> (xl_ok || xl_fault)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !xl_req |=> (!xl_ok && !xl_fault)); // R1
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    xl_fault |-> (pa == '0)); // R5
  AST_NO_STALE_PA: assert property (@(posedge clk) disable iff (rst)
    !xl_ok |-> (pa == '0)); // R5
endmodule

bind segxlate_top segxlate_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .xl_req   (xl_req),
  .pa       (pa),
  .xl_ok    (xl_ok),
  .xl_fault (xl_fault)
);

// File: tb/segxlate_top_test.sv
module segxlate_top_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        tw_en = 0;
  logic [1:0]  tw_idx = 0;
  logic [29:0] tw_base = 0;
  logic [29:0] tw_bound = 0;
  logic        xl_req = 0;
  logic [31:0] va = 0;
  logic [29:0] pa;
  logic        xl_ok, xl_fault;
  int n_run = 0, n_bad = 0;

  always #10 clk = ~clk;

  segxlate_top uut (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] i, logic [29:0] b, logic [29:0] bd);
    @(negedge clk);
    tw_en = 1; tw_idx = i; tw_base = b; tw_bound = bd;
    @(negedge clk);
    tw_en = 0;
  endtask

  // issue one request, sample result next cycle
  task automatic xl(string r, logic [31:0] a, bit okx, logic [29:0] pax);
    @(negedge clk);
    xl_req = 1; va = a;
    @(negedge clk);
    xl_req = 0;
    chk(r, {31'd0, xl_ok}, {31'd0, okx});
    chk(r, {31'd0, xl_fault}, {31'd0, !okx});
    chk(r, {2'd0, pa}, okx ? {2'd0, pax} : 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", {30'd0, xl_ok, xl_fault}, 0);
    xl("R7", 32'h4000_0000, 1, 0);
    xl("R7", 32'h8000_0001, 0, 0);
    @(negedge clk);
    chk("R1", {30'd0, xl_ok, xl_fault}, 0);
  endtask

  task automatic t_example();
    wr(0, 30'h4000, 30'h700);
    wr(1, 30'h0, 30'h500);
    wr(2, 30'h2000, 30'h1000);
    xl("R4", 32'h8000_0200, 1, 30'h2200);
    xl("R3", 32'h0000_0100, 1, 30'h4100);
    xl("R4", 32'h0000_0700, 1, 30'h4700);
    xl("R5", 32'h0000_0701, 0, 0);
    xl("R5", 32'h4000_0501, 0, 0);
    xl("R3", 32'h4000_0500, 1, 30'h500);
  endtask

  task automatic t_wrap();
    wr(3, 30'h3FFF_FF00, 30'h3FFF_FFFF);
    xl("R4", 32'hC000_0180, 1, 30'h80);
    xl("R4", 32'hFFFF_FFFF, 1, 30'h3FFF_FEFF);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    tw_en = 1; tw_idx = 1; tw_base = 30'h9000; tw_bound = 30'h10;
    xl_req = 1; va = 32'h4000_0400;
    @(negedge clk);
    tw_en = 0; xl_req = 0;
    chk("R6", {31'd0, xl_ok}, 1);
    chk("R6", {2'd0, pa}, 32'h400);
    xl("R6", 32'h4000_0400, 0, 0);
    xl("R6", 32'h4000_0010, 1, 30'h9010);
    xl("R8", 32'h8000_0200, 1, 30'h2200);
    xl("R8", 32'h0000_0000, 1, 30'h4000);
  endtask

  task automatic t_back2back();
    @(negedge clk);
    xl_req = 1; va = 32'h8000_0005;
    @(negedge clk);
    chk("R2", {31'd0, xl_ok}, 1);
    chk("R2", {2'd0, pa}, 32'h2005);
    va = 32'h8000_2000;
    @(negedge clk);
    xl_req = 0;
    chk("R2", {30'd0, xl_ok, xl_fault}, 1);
    @(negedge clk);
    chk("R1", {30'd0, xl_ok, xl_fault}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_example();
    t_wrap();
    t_same_cycle();
    t_back2back();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule